// File: doc/BRIEF.md
# External Interrupt Sense Unit

The unit watches a set of asynchronous interrupt request lines (eight by default). It turns each one into a per-line status flag and a per-line interrupt output for a downstream interrupt controller. Every line is first passed through a two-flop synchroniser. An event detector then applies the sense mode that software has chosen for that line: active-low level, falling edge, rising edge, or either edge.

Software uses a small word-addressed register interface. A mode register holds one 2-bit sense field per line. A read-only status register holds one flag per line. A write-one-to-clear register acknowledges edge events. In level mode a flag mirrors the request and drops by itself when the source releases the line. In the edge modes a flag latches until software clears it. An edge that arrives in the same cycle as a clear of that line wins, so no event is lost.

Top module: `irq_sense_unit`

## Requirements
- R1: The mode register at address 0 holds line i's sense field at bits [2i+1:2i], with the encoding 00 low level, 01 falling edge, 10 rising edge and 11 both edges. A write updates it on the next clock edge, and it reads back unchanged.
- R2: In low-level mode, status bit i is 1 exactly while the synchronised line i is low. It drops without software action once the line returns high.
- R3: In the edge modes, status bit i is set by a high-to-low change (01), a low-to-high change (10), or either change (11) of line i. The flag is not set by the other direction.
- R4: A change on irq_i appears in the status register after exactly three rising clock edges: two synchroniser stages and then the flag register.
- R5: In an edge mode, a set flag stays set until software writes 1 to bit i of the clear register at address 2. That write clears it on the next clock edge.
- R6: A clear write has no effect on a line in low-level mode. A low line in that mode keeps status 1 after the write.
- R7: When an edge event and a clear write hit the same line in the same cycle, the flag remains set.
- R8: irq_o[i] always equals status bit i. The status register is at address 1, bit i per line. Writes to address 1 change nothing, and reads of address 2 return 0.
- R9: After reset every sense field is 00, and every status bit and irq_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LINES | Asynchronous interrupt request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from address |
| irq_o | output | NUM_LINES | Per-line interrupt output, equal to status |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle in which a synchronised edge reaches the flag logic. The bench first sets a line's flag with an earlier rising edge. It then changes the input, waits two clock edges for the synchroniser, and drives the clear strobe so that it coincides with the third edge. A following plain clear confirms that the clear path itself works. A sweep over uniform and mixed mode configurations then steps the inputs through toggling patterns against an arithmetic per-line model.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int unsigned ADDR_MODE   = 0;
  localparam int unsigned ADDR_STATUS = 1;
  localparam int unsigned ADDR_CLEAR  = 2;
endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to the idle (high) level so no event fires on reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("synchroniser needs two stages");
  end
endmodule

// File: rtl/irq_sense_line.sv
module irq_sense_line
  import irq_sense_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   smp_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   flag_o
);
  logic prev_q, flag_q, flag_d;
  logic rise, fall, evt;

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      SENSE_BOTH: evt = rise | fall;
      default:    evt = 1'b0;
    endcase
  end

  always_comb begin
    if (mode_i == SENSE_LOW) flag_d = ~smp_i;
    else if (evt)            flag_d = 1'b1;  // set wins over clear
    else if (clr_i)          flag_d = 1'b0;
    else                     flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_level_tracks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_LOW) |=> (flag_q == ~prev_q));

  assert_edge_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && flag_q && !clr_i) |=> flag_q);

  assert_clear_acts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && clr_i && !rise && !fall) |=> !flag_q);

  assert_rise_seen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == SENSE_RISE || mode_i == SENSE_BOTH) && rise) |=> flag_q);

  assert_fall_seen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == SENSE_FALL || mode_i == SENSE_BOTH) && fall) |=> flag_q);

  assert_event_beats_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && evt && clr_i) |=> flag_q);
endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [NUM_LINES-1:0]   status_i,
  output logic [2*NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0]   clr_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int unsigned MODE_W = 2 * NUM_LINES;

  logic [MODE_W-1:0] mode_q;
  logic              wr_mode, wr_clr;

  assign wr_mode = we_i && (addr_i == ADDR_W'(ADDR_MODE));
  assign wr_clr  = we_i && (addr_i == ADDR_W'(ADDR_CLEAR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_mode) mode_q <= wdata_i[MODE_W-1:0];
  end

  assign mode_o = mode_q;
  assign clr_o  = wr_clr ? wdata_i[NUM_LINES-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_MODE))        rdata_o[MODE_W-1:0]    = mode_q;
    else if (addr_i == ADDR_W'(ADDR_STATUS)) rdata_o[NUM_LINES-1:0] = status_i;
  end

  generate
    if (DATA_W > MODE_W) begin : g_spare
      logic unused_wdata;
      assign unused_wdata = ^wdata_i[DATA_W-1:MODE_W];
    end
  endgenerate

  assert_mode_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> (mode_q == $past(wdata_i[MODE_W-1:0])));

  assert_mode_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode |=> $stable(mode_q));

  initial begin
    assert (DATA_W >= MODE_W) else $error("data width too small for mode register");
  end
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irq_sense_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned MODE_W = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] smp, clr, status;
  logic [MODE_W-1:0]    mode;

  irq_sense_sync #(.WIDTH(NUM_LINES), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (smp)
  );

  irq_sense_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .status_i(status),
    .mode_o  (mode),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_sense_line i_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (smp[i]),
      .mode_i(sense_e'(mode[2*i +: 2])),
      .clr_i (clr[i]),
      .flag_o(status[i])
    );
  end

  assign irq_o = status;

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
endmodule

// File: tb/test_irq_sense_unit.sv
`timescale 1ns/1ps
module test_irq_sense_unit;
  localparam int N = 8;
  localparam int AW = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '1;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_sense_unit #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW)) i_irq_sense_unit (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  // drive input, then wait three rising edges (two sync stages + flag)
  task automatic set_in(input logic [N-1:0] v);
    @(negedge clk);
    irq = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [N-1:0] model(input logic [15:0] cfg, input logic [N-1:0] p,
                                         input logic [N-1:0] c, input logic [N-1:0] e);
    logic [N-1:0] r = e;
    for (int i = 0; i < N; i++) begin
      case (cfg[2*i +: 2])
        2'b00: r[i] = ~c[i];
        2'b01: if (p[i] && !c[i]) r[i] = 1'b1;
        2'b10: if (!p[i] && c[i]) r[i] = 1'b1;
        default: if (p[i] != c[i]) r[i] = 1'b1;
      endcase
    end
    return r;
  endfunction

  function automatic logic [N-1:0] after_clear(input logic [15:0] cfg, input logic [N-1:0] c,
                                               input logic [N-1:0] e);
    logic [N-1:0] r = e;
    for (int i = 0; i < N; i++) r[i] = (cfg[2*i +: 2] == 2'b00) ? ~c[i] : 1'b0;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] cfgs [5];
    logic [N-1:0] prev, exp, nv;
    cfgs[0] = 16'h0000; cfgs[1] = 16'h5555; cfgs[2] = 16'hAAAA;
    cfgs[3] = 16'hFFFF; cfgs[4] = 16'hE4E4;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, d); chk("R9 mode after reset", d, 32'h0);
    rd(1, d); chk("R9 status after reset", d, 32'h0);
    chk("R9 irq_o after reset", 32'(irq_out), 32'h0);

    // R2 / R6: level line, clear ignored, self-clear
    set_in(8'hFB);
    rd(1, d); chk("R2 level line low sets status", d, 32'h04);
    wr(2, 32'hFF);
    rd(1, d); chk("R6 clear ignored in level mode", d, 32'h04);
    set_in(8'hFF);
    rd(1, d); chk("R2 level status self-clears", d, 32'h0);

    // R4 latency: rising mode on line 0, check after two edges then third
    wr(0, 32'hAAAA);
    set_in(8'hFE);
    wr(2, 32'hFF);
    @(negedge clk); irq = 8'hFF;
    repeat (2) @(negedge clk);
    rd(1, d); chk("R4 not yet visible after two edges", d, 32'h0);
    @(negedge clk);
    rd(1, d); chk("R4 visible after third edge", d, 32'h01);

    // R7: flag already set, new rising edge collides with clear
    set_in(8'hFE);
    rd(1, d); chk("R5 flag held with no clear", d, 32'h01);
    @(negedge clk); irq = 8'hFF;
    repeat (2) @(negedge clk);
    we = 1'b1; addr = AW'(2); wdata = 32'h01;
    @(negedge clk); we = 1'b0;
    rd(1, d); chk("R7 edge beats same-cycle clear", d, 32'h01);
    wr(2, 32'h01);
    rd(1, d); chk("R5 clear removes edge flag", d, 32'h0);

    // R8: status read-only, clear address reads zero
    set_in(8'hFE); set_in(8'hFF);
    wr(1, 32'h0);
    rd(1, d); chk("R8 status write ignored", d, 32'h01);
    rd(2, d); chk("R8 clear register reads zero", d, 32'h0);
    chk("R8 irq_o equals status", 32'(irq_out), 32'h01);

    // sweep over mode configurations
    foreach (cfgs[k]) begin
      wr(0, 32'(cfgs[k]));
      rd(0, d); chk("R1 mode readback", d, 32'(cfgs[k]));
      set_in(8'hFF);
      wr(2, 32'hFF);
      prev = 8'hFF; exp = '0;
      rd(1, d); chk("R5 sweep start clear", d, 32'h0);
      for (int s = 0; s < 12; s++) begin
        nv = ~prev ^ N'(s * 37 + k * 11);
        set_in(nv);
        exp = model(cfgs[k], prev, nv, exp);
        prev = nv;
        rd(1, d); chk("R3 sweep status", d, 32'(exp));
        chk("R8 sweep irq_o", 32'(irq_out), 32'(exp));
        if (s % 3 == 2) begin
          wr(2, 32'hFF);
          exp = after_clear(cfgs[k], prev, exp);
          rd(1, d); chk("R5 sweep after clear", d, 32'(exp));
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule